// File: doc/BRIEF.md
# Serial Controller Register Frontend

This block is the register-side half of a serial controller. A 32-bit processor bus reaches it through simple read and write strobes. It holds the settings that a separate shift engine consumes: the global enable, the clock setup, the transmit and receive word formats, the frame setup and the FIFO thresholds. It also holds two word FIFOs that sit between software and the engine. One bus address is shared by both directions. A write to it queues a word for transmission, and a read from it takes the oldest received word.

The engine pulls transmit words, delivers received words and reports a busy level and a transmit-complete pulse. The frontend turns FIFO occupancy into status bits. It latches three interrupt causes (transmit complete, receive complete, receive overrun). Software clears a cause by writing a one to its bit, and a single interrupt line reports any enabled cause that is pending. All read data is registered: a read issued in one cycle shows its value on `bus_rdata` from the next cycle on.

Top module: `spi_reg_front`

## Requirements
- R1: After reset every configuration register, the interrupt enables and the pending causes are zero, both FIFOs are empty, `irq` is low, and the status word reads 0x20.
- R2: The configuration registers keep only their defined bits and read those bits back one cycle after the read strobe. The registers and their writable bits are: control at 0x00 (bit 0), clock at 0x04 (bits 14:12 and 7:0), transmit format at 0x08 (bits 13:0), receive format at 0x0C (bits 7:0), frame at 0x10 (bits 15:14) and interrupt enable at 0x18 (bits 4, 3, 0). Offsets outside the map read zero, and writes to them change no register.
- R3: A write to 0x24 queues bits WORD_W-1:0 of the write data into the transmit FIFO. `eng_tx_valid` is high only while control bit 0 is set and the FIFO holds a word. A `eng_tx_take` pulse accepted in that state presents the oldest word on `eng_tx_data` in the following cycle, in write order. A take while control bit 0 is clear removes nothing.
- R4: A read of 0x24 removes the oldest receive word and returns it zero-extended. A read of 0x24 with the receive FIFO empty returns zero and leaves the FIFO unchanged.
- R5: Each FIFO holds FIFO_DEPTH (8) words. A data write while the transmit FIFO is full is discarded. A write and a take in the same cycle are both honoured.
- R6: The status word at 0x14 has bit 7 = `eng_busy` OR transmit FIFO not empty, bit 5 = transmit FIFO not full, and bit 0 = receive FIFO not empty. All other bits are zero.
- R7: In the FIFO control register at 0x20, writing bit 12 empties the transmit FIFO and writing bit 4 empties the receive FIFO. Both bits read back as zero. Bits 11:8 (transmit threshold) and 3:0 (receive threshold) keep their written values and drive `cfg_tx_thresh` and `cfg_rx_thresh`. An engine word that arrives in the same cycle as a receive flush is discarded.
- R8: An engine word that arrives while the receive FIFO is full is discarded, even if the bus reads the FIFO in that same cycle. It sets the overrun cause (bit 0) and does not set the receive-complete cause.
- R9: Address 0x1C reads the pending causes: bit 4 transmit complete (set by `eng_tx_done`), bit 3 receive complete (set by each accepted engine word) and bit 0 overrun. Writing a one to one of these bits clears that cause. A cause that is raised in the same cycle as its clear stays pending.
- R10: `irq` is high in the cycle after any pending cause whose enable bit is set, and low in the cycle after no such cause remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid from the cycle after `bus_rd` |
| irq | output | 1 | Enabled cause pending |
| cfg_enable | output | 1 | Global enable |
| cfg_clock | output | 32 | Clock setup register |
| cfg_txfmt | output | 32 | Transmit format register |
| cfg_rxfmt | output | 32 | Receive format register |
| cfg_frame | output | 32 | Frame setup register |
| cfg_tx_thresh | output | TH_W | Transmit FIFO threshold |
| cfg_rx_thresh | output | TH_W | Receive FIFO threshold |
| eng_tx_valid | output | 1 | A transmit word is available to the engine |
| eng_tx_take | input | 1 | Engine takes the oldest transmit word |
| eng_tx_data | output | WORD_W | Word taken, valid the cycle after the take |
| eng_tx_done | input | 1 | Transmit-complete pulse from the engine |
| eng_busy | input | 1 | Engine is shifting |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | WORD_W | Received word |

## Verification
Three pairs of events can fall in the same cycle. A cause can be raised while software writes its clear bit. The bus can read a full receive FIFO while the engine delivers a word. A bus write to the data port can coincide with an engine take. The bench provokes each collision by driving both strobes on the same falling edge. It then judges the result through the pending-cause word, the order and count of words read back, and the words the engine receives. A receive flush that meets an engine delivery is judged the same way, through the status word.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;

  localparam int ADDR_W = 6;

  // Register byte offsets
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_CLKCFG = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_TXFMT  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_RXFMT  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_FRAME  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_IEN    = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_ICLR   = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_FCTL   = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_DATA   = 6'h24;

  // Writable bits per register
  localparam logic [31:0] MSK_CTRL   = 32'h0000_0001;
  localparam logic [31:0] MSK_CLKCFG = 32'h0000_70FF;
  localparam logic [31:0] MSK_TXFMT  = 32'h0000_3FFF;
  localparam logic [31:0] MSK_RXFMT  = 32'h0000_00FF;
  localparam logic [31:0] MSK_FRAME  = 32'h0000_C000;
  localparam logic [31:0] MSK_CAUSE  = 32'h0000_0019;

  // Status bit positions
  localparam int ST_BUSY = 7;
  localparam int ST_TXNF = 5;
  localparam int ST_RXNE = 0;

  // FIFO control bit positions
  localparam int FC_TXFLUSH = 12;
  localparam int FC_RXFLUSH = 4;
  localparam int FC_TXTH_LO = 8;
  localparam int FC_RXTH_LO = 0;

  // Cause positions in the register word
  localparam int CB_TXDONE = 4;
  localparam int CB_RXDONE = 3;
  localparam int CB_OVR    = 0;

  // Cause index inside the latch vector
  typedef enum int {CI_OVR = 0, CI_RXD = 1, CI_TXD = 2} cause_idx_e;
  localparam int N_CAUSE = 3;

endpackage

// File: rtl/rf_fifo.sv
module rf_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt;
  logic             push_ok, pop_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= din;
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst)         dout <= '0;
    else if (pop_ok) dout <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wptr <= nxt(wptr);
      if (pop_ok)  rptr <= nxt(rptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  a_r5_full_drop: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !flush) |=> full);
  a_r4_empty_pop_still: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push) |=> (empty && $stable(dout)));
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);

endmodule

// File: rtl/rf_irq.sv
module rf_irq #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] pend,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      irq  <= 1'b0;
    end else begin
      pend <= (pend & ~clr) | set;   // a raise outranks a clear
      irq  <= |(pend & en);
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> pend[i]);
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !set[i]) |=> !pend[i]);
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
      (pend[i] && !clr[i]) |=> pend[i]);
  end

  a_r10_irq_low: assert property (@(posedge clk) disable iff (rst)
    (pend & en) == '0 |=> !irq);

endmodule

// File: rtl/spi_reg_front.sv
module spi_reg_front
  import spi_rf_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int TH_W       = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              cfg_enable,
  output logic [31:0]       cfg_clock,
  output logic [31:0]       cfg_txfmt,
  output logic [31:0]       cfg_rxfmt,
  output logic [31:0]       cfg_frame,
  output logic [TH_W-1:0]   cfg_tx_thresh,
  output logic [TH_W-1:0]   cfg_rx_thresh,
  output logic              eng_tx_valid,
  input  logic              eng_tx_take,
  output logic [WORD_W-1:0] eng_tx_data,
  input  logic              eng_tx_done,
  input  logic              eng_busy,
  input  logic              eng_rx_push,
  input  logic [WORD_W-1:0] eng_rx_data
);
  logic [31:0] ctrl_q, clk_q, txf_q, rxf_q, frm_q, ien_q;
  logic [TH_W-1:0] txth_q, rxth_q;

  logic wr_ctrl, wr_clk, wr_txf, wr_rxf, wr_frm, wr_ien, wr_iclr, wr_fctl, wr_data;
  logic rd_data;
  logic tx_flush, rx_flush, tx_pop;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic [WORD_W-1:0] rx_dout;
  logic rx_push_ok;

  logic [N_CAUSE-1:0] c_set, c_clr, c_en, c_pend;
  logic [31:0] cause_word, stat_word, rd_mux;
  logic [31:0] rdata_q;
  logic        sel_data_q, data_ok_q;

  // ---------------- decode ----------------
  assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_clk  = bus_wr && (bus_addr == OFS_CLKCFG);
  assign wr_txf  = bus_wr && (bus_addr == OFS_TXFMT);
  assign wr_rxf  = bus_wr && (bus_addr == OFS_RXFMT);
  assign wr_frm  = bus_wr && (bus_addr == OFS_FRAME);
  assign wr_ien  = bus_wr && (bus_addr == OFS_IEN);
  assign wr_iclr = bus_wr && (bus_addr == OFS_ICLR);
  assign wr_fctl = bus_wr && (bus_addr == OFS_FCTL);
  assign wr_data = bus_wr && (bus_addr == OFS_DATA);
  assign rd_data = bus_rd && (bus_addr == OFS_DATA);

  // ---------------- configuration registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      clk_q  <= '0;
      txf_q  <= '0;
      rxf_q  <= '0;
      frm_q  <= '0;
      ien_q  <= '0;
      txth_q <= '0;
      rxth_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= bus_wdata & MSK_CTRL;
      if (wr_clk)  clk_q  <= bus_wdata & MSK_CLKCFG;
      if (wr_txf)  txf_q  <= bus_wdata & MSK_TXFMT;
      if (wr_rxf)  rxf_q  <= bus_wdata & MSK_RXFMT;
      if (wr_frm)  frm_q  <= bus_wdata & MSK_FRAME;
      if (wr_ien)  ien_q  <= bus_wdata & MSK_CAUSE;
      if (wr_fctl) begin
        txth_q <= bus_wdata[FC_TXTH_LO +: TH_W];
        rxth_q <= bus_wdata[FC_RXTH_LO +: TH_W];
      end
    end
  end

  assign cfg_enable    = ctrl_q[0];
  assign cfg_clock     = clk_q;
  assign cfg_txfmt     = txf_q;
  assign cfg_rxfmt     = rxf_q;
  assign cfg_frame     = frm_q;
  assign cfg_tx_thresh = txth_q;
  assign cfg_rx_thresh = rxth_q;

  // ---------------- FIFOs ----------------
  assign tx_flush = wr_fctl && bus_wdata[FC_TXFLUSH];
  assign rx_flush = wr_fctl && bus_wdata[FC_RXFLUSH];
  assign tx_pop   = eng_tx_take && ctrl_q[0];

  rf_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .push(wr_data), .din(bus_wdata[WORD_W-1:0]),
    .pop(tx_pop), .dout(eng_tx_data),
    .full(tx_full), .empty(tx_empty)
  );

  rf_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(rx_flush),
    .push(eng_rx_push), .din(eng_rx_data),
    .pop(rd_data), .dout(rx_dout),
    .full(rx_full), .empty(rx_empty)
  );

  assign eng_tx_valid = ctrl_q[0] && !tx_empty;
  assign rx_push_ok   = eng_rx_push && !rx_full && !rx_flush;

  // ---------------- interrupt causes ----------------
  always_comb begin
    c_set = '0;
    c_clr = '0;
    c_en  = '0;
    c_set[CI_OVR] = eng_rx_push && rx_full;
    c_set[CI_RXD] = rx_push_ok;
    c_set[CI_TXD] = eng_tx_done;
    c_clr[CI_OVR] = wr_iclr && bus_wdata[CB_OVR];
    c_clr[CI_RXD] = wr_iclr && bus_wdata[CB_RXDONE];
    c_clr[CI_TXD] = wr_iclr && bus_wdata[CB_TXDONE];
    c_en[CI_OVR]  = ien_q[CB_OVR];
    c_en[CI_RXD]  = ien_q[CB_RXDONE];
    c_en[CI_TXD]  = ien_q[CB_TXDONE];
  end

  rf_irq #(.N(N_CAUSE)) u_irq (
    .clk(clk), .rst(rst), .set(c_set), .clr(c_clr), .en(c_en),
    .pend(c_pend), .irq(irq)
  );

  // ---------------- read path ----------------
  always_comb begin
    cause_word = '0;
    cause_word[CB_OVR]    = c_pend[CI_OVR];
    cause_word[CB_RXDONE] = c_pend[CI_RXD];
    cause_word[CB_TXDONE] = c_pend[CI_TXD];
    stat_word = '0;
    stat_word[ST_BUSY] = eng_busy || !tx_empty;
    stat_word[ST_TXNF] = !tx_full;
    stat_word[ST_RXNE] = !rx_empty;
  end

  always_comb begin
    case (bus_addr)
      OFS_CTRL:   rd_mux = ctrl_q;
      OFS_CLKCFG: rd_mux = clk_q;
      OFS_TXFMT:  rd_mux = txf_q;
      OFS_RXFMT:  rd_mux = rxf_q;
      OFS_FRAME:  rd_mux = frm_q;
      OFS_STAT:   rd_mux = stat_word;
      OFS_IEN:    rd_mux = ien_q;
      OFS_ICLR:   rd_mux = cause_word;
      OFS_FCTL:   rd_mux = (32'(txth_q) << FC_TXTH_LO) | (32'(rxth_q) << FC_RXTH_LO);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q    <= '0;
      sel_data_q <= 1'b0;
      data_ok_q  <= 1'b0;
    end else if (bus_rd) begin
      rdata_q    <= rd_mux;
      sel_data_q <= rd_data;
      data_ok_q  <= rd_data && !rx_empty;
    end
  end

  assign bus_rdata = sel_data_q ? (data_ok_q ? 32'(rx_dout) : '0) : rdata_q;

  a_r4_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_data && rx_empty) |=> (bus_rdata == '0));
  a_r8_overrun_keeps_full: assert property (@(posedge clk) disable iff (rst)
    (eng_rx_push && rx_full && !rd_data && !rx_flush) |=> rx_full);
  a_r3_gated_take: assert property (@(posedge clk) disable iff (rst)
    (eng_tx_take && !ctrl_q[0] && !wr_data && !tx_flush) |=> $stable(tx_empty));

endmodule

// File: tb/spi_reg_front_bench.sv
module spi_reg_front_bench;
  import spi_rf_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WW = 16;
  localparam int DP = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 0, bus_rd = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq, cfg_enable;
  logic [31:0] cfg_clock, cfg_txfmt, cfg_rxfmt, cfg_frame;
  logic [3:0] cfg_tx_thresh, cfg_rx_thresh;
  logic eng_tx_valid, eng_tx_take = 0, eng_tx_done = 0, eng_busy = 0, eng_rx_push = 0;
  logic [WW-1:0] eng_tx_data, eng_rx_data = '0;

  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_reg_front #(.WORD_W(WW), .FIFO_DEPTH(DP), .TH_W(4)) u_spi_reg_front (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .cfg_enable(cfg_enable), .cfg_clock(cfg_clock), .cfg_txfmt(cfg_txfmt),
    .cfg_rxfmt(cfg_rxfmt), .cfg_frame(cfg_frame),
    .cfg_tx_thresh(cfg_tx_thresh), .cfg_rx_thresh(cfg_rx_thresh),
    .eng_tx_valid(eng_tx_valid), .eng_tx_take(eng_tx_take), .eng_tx_data(eng_tx_data),
    .eng_tx_done(eng_tx_done), .eng_busy(eng_busy),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] v);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    v = bus_rdata;
  endtask

  task automatic epush(input logic [WW-1:0] d);
    eng_rx_push = 1; eng_rx_data = d;
    @(negedge clk);
    eng_rx_push = 0;
  endtask

  task automatic etake(output logic [WW-1:0] v);
    eng_tx_take = 1;
    @(negedge clk);
    eng_tx_take = 0;
    v = eng_tx_data;
  endtask

  function automatic logic [WW-1:0] pat(input int i);
    return WW'(i * 16'h1357 + 16'h0A0B);
  endfunction

  function automatic logic [31:0] cfg_mask(input int k);
    case (k)
      0: return MSK_CTRL;
      1: return MSK_CLKCFG;
      2: return MSK_TXFMT;
      3: return MSK_RXFMT;
      4: return MSK_FRAME;
      default: return MSK_CAUSE;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] cfg_ofs(input int k);
    case (k)
      0: return OFS_CTRL;
      1: return OFS_CLKCFG;
      2: return OFS_TXFMT;
      3: return OFS_RXFMT;
      4: return OFS_FRAME;
      default: return OFS_IEN;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [WW-1:0] w;
    logic [31:0] pats [4];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_A5A5;
    pats[2] = 32'h5A5A_5A5A; pats[3] = 32'h0;

    repeat (4) @(negedge clk);
    rst = 0;

    // R1: reset state
    for (int a = 0; a <= 9; a++) begin
      rd(ADDR_W'(a * 4), v);
      check("R1 reset read", v, (a == 5) ? 32'h20 : 32'h0);
    end
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 tx valid", {31'b0, eng_tx_valid}, 0);

    // R2: masked readback sweep
    for (int k = 0; k < 6; k++)
      for (int p = 0; p < 4; p++) begin
        wr(cfg_ofs(k), pats[p]);
        rd(cfg_ofs(k), v);
        check("R2 readback", v, pats[p] & cfg_mask(k));
      end
    wr(OFS_CLKCFG, 32'hFFFF_FFFF);
    check("R2 cfg_clock port", cfg_clock, MSK_CLKCFG);
    for (int a = 10; a < 16; a++) begin
      wr(ADDR_W'(a * 4), 32'hFFFF_FFFF);
      rd(ADDR_W'(a * 4), v);
      check("R2 unmapped", v, 0);
    end
    rd(OFS_CTRL, v);
    check("R2 unmapped write no effect", v, 0);

    // R3/R5/R6: fill transmit FIFO past depth with enable off
    for (int i = 0; i <= DP; i++) wr(OFS_DATA, 32'hFFFF_0000 | 32'(pat(i)));
    rd(OFS_STAT, v);
    check("R6 R5 status full", v, 32'h80);
    check("R3 valid gated", {31'b0, eng_tx_valid}, 0);
    etake(w);
    wr(OFS_CTRL, 1);
    check("R3 valid on", {31'b0, eng_tx_valid}, 1);
    for (int i = 0; i < DP; i++) begin
      etake(w);
      check("R3 tx order", 32'(w), 32'(pat(i)));
    end
    check("R5 ninth dropped", {31'b0, eng_tx_valid}, 0);
    rd(OFS_STAT, v);
    check("R6 idle status", v, 32'h20);
    eng_busy = 1;
    rd(OFS_STAT, v);
    check("R6 busy engine", v, 32'hA0);
    eng_busy = 0;

    // R5: write and take in the same cycle
    wr(OFS_DATA, 32'(pat(20)));
    eng_tx_take = 1; bus_wr = 1; bus_addr = OFS_DATA; bus_wdata = 32'(pat(21));
    @(negedge clk);
    eng_tx_take = 0; bus_wr = 0;
    check("R5 collide take word", 32'(eng_tx_data), 32'(pat(20)));
    check("R5 collide kept", {31'b0, eng_tx_valid}, 1);
    etake(w);
    check("R5 collide second", 32'(w), 32'(pat(21)));

    // R4/R8/R9: receive past depth
    for (int i = 0; i <= DP; i++) epush(pat(40 + i));
    rd(OFS_ICLR, v);
    check("R8 R9 causes", v, 32'h09);
    rd(OFS_STAT, v);
    check("R6 rx not empty", v, 32'h21);
    for (int i = 0; i < DP; i++) begin
      rd(OFS_DATA, v);
      check("R4 rx order", v, 32'(pat(40 + i)));
    end
    rd(OFS_DATA, v);
    check("R4 empty read zero", v, 0);
    rd(OFS_STAT, v);
    check("R4 empty unchanged", v, 32'h20);
    wr(OFS_ICLR, 32'h09);
    rd(OFS_ICLR, v);
    check("R9 clear", v, 0);

    // R9: raise and clear in the same cycle
    eng_tx_done = 1; bus_wr = 1; bus_addr = OFS_ICLR; bus_wdata = 32'h10;
    @(negedge clk);
    eng_tx_done = 0; bus_wr = 0;
    rd(OFS_ICLR, v);
    check("R9 set wins", v, 32'h10);

    // R10: interrupt line
    check("R10 disabled", {31'b0, irq}, 0);
    wr(OFS_IEN, 32'h10);
    @(negedge clk);
    check("R10 raised", {31'b0, irq}, 1);
    wr(OFS_ICLR, 32'h10);
    @(negedge clk);
    check("R10 dropped", {31'b0, irq}, 0);

    // R8: bus read and engine delivery on a full FIFO
    for (int i = 0; i < DP; i++) epush(pat(60 + i));
    wr(OFS_ICLR, 32'h19);
    bus_rd = 1; bus_addr = OFS_DATA; eng_rx_push = 1; eng_rx_data = 16'hBEEF;
    @(negedge clk);
    bus_rd = 0; eng_rx_push = 0;
    check("R8 collide read", bus_rdata, 32'(pat(60)));
    rd(OFS_ICLR, v);
    check("R8 overrun only", v, 32'h01);
    for (int i = 1; i < DP; i++) begin
      rd(OFS_DATA, v);
      check("R8 rest intact", v, 32'(pat(60 + i)));
    end
    rd(OFS_STAT, v);
    check("R8 drained", v, 32'h20);

    // R7: flush and thresholds
    wr(OFS_CTRL, 0);
    for (int i = 0; i < 3; i++) wr(OFS_DATA, 32'(pat(i)));
    for (int i = 0; i < 2; i++) epush(pat(i));
    wr(OFS_FCTL, 32'h0000_1315);
    rd(OFS_STAT, v);
    check("R7 both flushed", v, 32'h20);
    rd(OFS_FCTL, v);
    check("R7 readback", v, 32'h0000_0305);
    check("R7 tx thresh", 32'(cfg_tx_thresh), 3);
    check("R7 rx thresh", 32'(cfg_rx_thresh), 5);
    eng_rx_push = 1; eng_rx_data = 16'h1234;
    bus_wr = 1; bus_addr = OFS_FCTL; bus_wdata = 32'h0000_0010;
    @(negedge clk);
    eng_rx_push = 0; bus_wr = 0;
    rd(OFS_STAT, v);
    check("R7 flush beats push", v, 32'h20);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule